// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the control state machine that decides how one digital PLL clock generator runs. It watches a set of reference-valid flags, a frequency-lock indication from the loop, a flag saying whether holdover history exists, a revertive enable and manual override controls. From these it chooses one of four operating modes: free run, locking, locked and holdover. It also chooses which reference the loop follows.

Outside the controller sit the phase detector, loop filter and oscillator. They use the mode, the selected reference index and the frequency correction word. The controller drives three kinds of correction word. In free run it drives a signed calibration code sign-extended to the loop's word width. While locking or locked it passes the loop's own frequency word through. In holdover it drives the frequency word captured on the last locked cycle.

A sync status bit is high exactly while the mode is locked. The asynchronous active-low reset is released through a two-stage synchronizer. The controller therefore starts acting on the third rising edge after reset is released.

Top module: `clksync_mode_ctrl`

## Requirements
- R1: During reset and until the reset release has propagated, the outputs hold these values: mode is free run, sync is 0, selected index is 0, and the correction word is the sign-extended calibration code. Mode codes are 0 for free run, 1 for locking, 2 for locked and 3 for holdover.
- R2: In free run with no force active, any candidate reference moves the mode to locking on the next edge. Without manual select, the candidate is the lowest-index valid reference, so bit 0 of `ref_valid` has the highest priority.
- R3: From locking, the mode becomes locked on the edge where `freq_lock` is high and the candidate equals the selected reference. `sync_o` is 1 exactly while the mode is locked, and it clears on any exit.
- R4: If the active reference is lost while locked and no candidate exists, the next mode is holdover when `hist_avail` is 1 and free run otherwise.
- R5: If the active reference is lost while locked and another candidate is valid, the next mode is locking on that candidate.
- R6: With `revertive_en` at 1, a valid candidate of higher priority than the active reference sends the mode from locked back to locking on that candidate. With `revertive_en` at 0, the mode stays locked.
- R7: From holdover, any candidate reference returns the mode to locking on that reference.
- R8: `force_free` puts the mode in free run and holds it there, whatever the other inputs are, and it wins over `force_hold`. `force_hold` enters holdover when `hist_avail` is 1 and free run otherwise. While a force is held, reference changes move neither the mode nor the selected index.
- R9: The correction word follows the mode. In free run it is the 11-bit calibration code sign-extended. In locking and locked it is `loop_freq`. In holdover it is the `loop_freq` value present on the last locked edge, and it stays constant while holdover lasts.
- R10: When `man_sel_en` is 1, the only candidate is `man_sel_idx`, and it counts as a candidate only while its valid flag is set. While locked, a valid manual candidate that differs from the active reference causes locking on it. An invalid manual candidate counts as no reference even when other references are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | NUM_REFS | Per-reference valid flags, bit 0 highest priority |
| freq_lock | input | 1 | Frequency-lock indication from the loop |
| hist_avail | input | 1 | Holdover history available |
| revertive_en | input | 1 | Enable switch-back to a better reference |
| force_free | input | 1 | Manual free-run override |
| force_hold | input | 1 | Manual holdover override |
| man_sel_en | input | 1 | Manual reference selection enable |
| man_sel_idx | input | IDX_W | Manually selected reference index |
| cal_word | input | CAL_W | Signed free-run calibration code, 0.1 ppm per step |
| loop_freq | input | FREQ_W | Loop frequency word |
| mode_o | output | 2 | Current operating mode |
| sel_idx_o | output | IDX_W | Selected reference index |
| sync_o | output | 1 | Sync status, high while locked |
| freq_corr_o | output | FREQ_W | Frequency correction word |

## Verification
The hardest situation to reach from the ports is a holdover word that must differ from the live loop word. The bench locks on a reference and changes `loop_freq` while locked. It then drops every reference on a single edge with history available, and changes `loop_freq` again one cycle into holdover. The output must keep the value from the last locked edge. Revertive switching and the loss of a manually chosen reference are reached the same way: the bench first walks the controller into locked on a lower-priority or manual reference, then changes only `ref_valid` or the revertive and manual controls.

// File: rtl/clksync_pkg.sv
`timescale 1ns/1ps
package clksync_pkg;
  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_LOCKING = 2'd1,
    MODE_LOCKED  = 2'd2,
    MODE_HOLD    = 2'd3
  } mode_e;
endpackage

// File: rtl/clksync_rst_sync.sv
`timescale 1ns/1ps
module clksync_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_core_n = stage2_q;
endmodule

// File: rtl/clksync_ref_pick.sv
`timescale 1ns/1ps
module clksync_ref_pick #(
  parameter int NUM_REFS = 4,
  parameter int IDX_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic [NUM_REFS-1:0] ref_valid,
  input  logic                man_en,
  input  logic [IDX_W-1:0]    man_idx,
  output logic [IDX_W-1:0]    cand_idx,
  output logic                cand_ok
);
  logic [IDX_W-1:0] pri_idx;
  logic             pri_ok;
  logic             man_ok;

  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    pri_idx = '0;
    for (int i = NUM_REFS - 1; i >= 0; i--) begin
      if (ref_valid[i]) pri_idx = IDX_W'(i);
    end
    pri_ok = |ref_valid;
  end

  always_comb begin
    man_ok = 1'b0;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (man_idx == IDX_W'(i)) man_ok = ref_valid[i];
    end
  end

  assign cand_idx = man_en ? man_idx : pri_idx;
  assign cand_ok  = man_en ? man_ok  : pri_ok;
endmodule

// File: rtl/clksync_mode_fsm.sv
`timescale 1ns/1ps
module clksync_mode_fsm
  import clksync_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int IDX_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_valid,
  input  logic [IDX_W-1:0]    cand_idx,
  input  logic                cand_ok,
  input  logic                freq_lock,
  input  logic                hist_avail,
  input  logic                revertive_en,
  input  logic                man_en,
  input  logic                force_free,
  input  logic                force_hold,
  output mode_e               mode_q,
  output logic [IDX_W-1:0]    sel_q,
  output logic                sync_q
);
  mode_e            mode_d;
  logic [IDX_W-1:0] sel_d;
  logic             sel_en;
  logic             sync_d;
  logic             act_ok;
  logic             want_switch;
  mode_e            lost_mode;

  always_comb begin
    act_ok = 1'b0;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (sel_q == IDX_W'(i)) act_ok = ref_valid[i];
    end
  end

  assign lost_mode   = hist_avail ? MODE_HOLD : MODE_FREE;
  assign want_switch = cand_ok && (cand_idx != sel_q) &&
                       (man_en || (revertive_en && (cand_idx < sel_q)));

  always_comb begin
    mode_d = mode_q;
    sel_d  = cand_idx;
    sel_en = 1'b0;
    if (force_free) begin
      mode_d = MODE_FREE;
    end else if (force_hold) begin
      mode_d = lost_mode;
    end else begin
      unique case (mode_q)
        MODE_FREE, MODE_HOLD: begin
          if (cand_ok) begin
            mode_d = MODE_LOCKING;
            sel_en = 1'b1;
          end
        end
        MODE_LOCKING: begin
          if (!cand_ok) begin
            mode_d = lost_mode;
          end else begin
            sel_en = 1'b1;
            if (freq_lock && (cand_idx == sel_q)) mode_d = MODE_LOCKED;
          end
        end
        MODE_LOCKED: begin
          if (want_switch || !act_ok) begin
            if (cand_ok) begin
              mode_d = MODE_LOCKING;
              sel_en = 1'b1;
            end else begin
              mode_d = lost_mode;
            end
          end
        end
        default: mode_d = MODE_FREE;
      endcase
    end
    sync_d = (mode_d == MODE_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      sync_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/clksync_freq_out.sv
`timescale 1ns/1ps
module clksync_freq_out
  import clksync_pkg::*;
#(
  parameter int CAL_W  = 11,
  parameter int FREQ_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode_q,
  input  logic [CAL_W-1:0]  cal_word,
  input  logic [FREQ_W-1:0] loop_freq,
  output logic [FREQ_W-1:0] freq_corr
);
  localparam int EXT_W = FREQ_W - CAL_W;

  logic [FREQ_W-1:0] hold_word_q;
  logic              hold_cap_en;
  logic [FREQ_W-1:0] cal_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign cal_ext = {{EXT_W{cal_word[CAL_W-1]}}, cal_word};
    end else begin : g_trunc
      assign cal_ext = cal_word[FREQ_W-1:0];
    end
  endgenerate

  assign hold_cap_en = (mode_q == MODE_LOCKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word_q <= '0;
    end else if (hold_cap_en) begin
      hold_word_q <= loop_freq;
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_FREE: freq_corr = cal_ext;
      MODE_HOLD: freq_corr = hold_word_q;
      default:   freq_corr = loop_freq;
    endcase
  end
endmodule

// File: rtl/clksync_mode_ctrl.sv
`timescale 1ns/1ps
module clksync_mode_ctrl
  import clksync_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int CAL_W    = 11,
  parameter int FREQ_W   = 24,
  parameter int IDX_W    = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REFS-1:0] ref_valid,
  input  logic                freq_lock,
  input  logic                hist_avail,
  input  logic                revertive_en,
  input  logic                force_free,
  input  logic                force_hold,
  input  logic                man_sel_en,
  input  logic [IDX_W-1:0]    man_sel_idx,
  input  logic [CAL_W-1:0]    cal_word,
  input  logic [FREQ_W-1:0]   loop_freq,
  output logic [1:0]          mode_o,
  output logic [IDX_W-1:0]    sel_idx_o,
  output logic                sync_o,
  output logic [FREQ_W-1:0]   freq_corr_o
);
  logic             rst_core_n;
  logic [IDX_W-1:0] cand_idx;
  logic             cand_ok;
  mode_e            mode_q;

  clksync_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  clksync_ref_pick #(.NUM_REFS(NUM_REFS), .IDX_W(IDX_W)) u_pick (
    .ref_valid (ref_valid),
    .man_en    (man_sel_en),
    .man_idx   (man_sel_idx),
    .cand_idx  (cand_idx),
    .cand_ok   (cand_ok)
  );

  clksync_mode_fsm #(.NUM_REFS(NUM_REFS), .IDX_W(IDX_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .ref_valid    (ref_valid),
    .cand_idx     (cand_idx),
    .cand_ok      (cand_ok),
    .freq_lock    (freq_lock),
    .hist_avail   (hist_avail),
    .revertive_en (revertive_en),
    .man_en       (man_sel_en),
    .force_free   (force_free),
    .force_hold   (force_hold),
    .mode_q       (mode_q),
    .sel_q        (sel_idx_o),
    .sync_q       (sync_o)
  );

  clksync_freq_out #(.CAL_W(CAL_W), .FREQ_W(FREQ_W)) u_freq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .mode_q    (mode_q),
    .cal_word  (cal_word),
    .loop_freq (loop_freq),
    .freq_corr (freq_corr_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/clksync_mode_chk.sv
`timescale 1ns/1ps
module clksync_mode_chk #(
  parameter int NUM_REFS = 4,
  parameter int FREQ_W   = 24
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic [NUM_REFS-1:0] ref_valid,
  input logic                force_free,
  input logic                force_hold,
  input logic                man_sel_en,
  input logic [1:0]          mode_o,
  input logic                sync_o,
  input logic [FREQ_W-1:0]   freq_corr_o
);
  // R3: sync can only rise when leaving locking for locked
  a_r3_sync_from_locking: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sync_o) |-> ($past(mode_o) == 2'd1 && mode_o == 2'd2));

  // R3: sync and locked mode move together
  a_r3_sync_tracks_locked: assert property (@(posedge clk) disable iff (!rst_core_n)
    sync_o == (mode_o == 2'd2));

  // R2: free run with a reference and no override goes to locking
  a_r2_free_to_locking: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_o == 2'd0 && (|ref_valid) && !force_free && !force_hold && !man_sel_en)
      |=> mode_o == 2'd1);

  // R8: forced free run always lands in free run
  a_r8_force_free: assert property (@(posedge clk) disable iff (!rst_core_n)
    force_free |=> mode_o == 2'd0);

  // R9: holdover correction word does not move during holdover
  a_r9_hold_word_stable: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_o == 2'd3) |=> (mode_o != 2'd3 || $stable(freq_corr_o)));

  // R3: locked is entered only from locking
  a_r3_locked_entry: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);
endmodule

bind clksync_mode_ctrl clksync_mode_chk #(.NUM_REFS(NUM_REFS), .FREQ_W(FREQ_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .ref_valid   (ref_valid),
  .force_free  (force_free),
  .force_hold  (force_hold),
  .man_sel_en  (man_sel_en),
  .mode_o      (mode_o),
  .sync_o      (sync_o),
  .freq_corr_o (freq_corr_o)
);

// File: tb/sim_clksync_mode_ctrl.sv
`timescale 1ns/1ps
module sim_clksync_mode_ctrl;
  localparam int NR = 4;
  localparam int IW = 2;
  localparam int FW = 24;
  localparam logic [1:0] M_FREE = 2'd0, M_LKG = 2'd1, M_LKD = 2'd2, M_HOLD = 2'd3;
  localparam logic [FW-1:0] CAL = 24'hFFFFFB;

  typedef struct {
    logic [1:0]    mode;
    int            sel;
    logic          sync;
    logic [FW-1:0] corr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NR-1:0] ref_valid;
  logic          freq_lock, hist_avail, revertive_en, force_free, force_hold, man_sel_en;
  logic [IW-1:0] man_sel_idx;
  logic [10:0]   cal_word;
  logic [FW-1:0] loop_freq;
  logic [1:0]    mode_o;
  logic [IW-1:0] sel_idx_o;
  logic          sync_o;
  logic [FW-1:0] freq_corr_o;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  always #2.5 clk = ~clk;

  clksync_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .freq_lock(freq_lock),
    .hist_avail(hist_avail), .revertive_en(revertive_en), .force_free(force_free),
    .force_hold(force_hold), .man_sel_en(man_sel_en), .man_sel_idx(man_sel_idx),
    .cal_word(cal_word), .loop_freq(loop_freq), .mode_o(mode_o),
    .sel_idx_o(sel_idx_o), .sync_o(sync_o), .freq_corr_o(freq_corr_o)
  );

  // Driver: queue what the next rising edge must produce, then wait a cycle.
  task automatic step(input logic [1:0] m, input int s, input logic y,
                      input logic [FW-1:0] c, input string tag);
    exp_t e;
    e.mode = m; e.sel = s; e.sync = y; e.corr = c; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare one queued item just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (mode_o !== e.mode || int'(sel_idx_o) != e.sel || sync_o !== e.sync ||
          freq_corr_o !== e.corr) begin
        bad++;
        $display("FAIL %s: got mode=%0d sel=%0d sync=%0b corr=%h, want mode=%0d sel=%0d sync=%0b corr=%h",
                 e.tag, mode_o, sel_idx_o, sync_o, freq_corr_o, e.mode, e.sel, e.sync, e.corr);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_valid = '0; freq_lock = 0; hist_avail = 0; revertive_en = 0;
    force_free = 0; force_hold = 0; man_sel_en = 0; man_sel_idx = '0;
    cal_word = 11'h7FB; loop_freq = 24'h000100;
    @(negedge clk);
    step(M_FREE, 0, 0, CAL, "R1 reset");
    step(M_FREE, 0, 0, CAL, "R1 reset");
    rst_n = 1'b1;
    step(M_FREE, 0, 0, CAL, "R1 release");
    step(M_FREE, 0, 0, CAL, "R1 release");
    step(M_FREE, 0, 0, CAL, "R1 idle");
    // R2: priority pick among refs 1 and 2
    ref_valid = 4'b0110;
    step(M_LKG, 1, 0, 24'h000100, "R2 free to locking");
    step(M_LKG, 1, 0, 24'h000100, "R3 wait lock");
    freq_lock = 1;
    step(M_LKD, 1, 1, 24'h000100, "R3 locked sync");
    loop_freq = 24'h000321;
    step(M_LKD, 1, 1, 24'h000321, "R9 tracks loop");
    // R6: non-revertive keeps the lower reference
    ref_valid = 4'b0111;
    step(M_LKD, 1, 1, 24'h000321, "R6 non-revertive stays");
    revertive_en = 1;
    step(M_LKG, 0, 0, 24'h000321, "R6 revert to ref0");
    step(M_LKD, 0, 1, 24'h000321, "R3 relock");
    // R5: active lost, another valid
    ref_valid = 4'b0110;
    step(M_LKG, 1, 0, 24'h000321, "R5 switch on loss");
    step(M_LKD, 1, 1, 24'h000321, "R5 relock");
    // R4: all lost with history
    ref_valid = 4'b0000; hist_avail = 1;
    step(M_HOLD, 1, 0, 24'h000321, "R4 holdover");
    loop_freq = 24'h000999;
    step(M_HOLD, 1, 0, 24'h000321, "R9 hold word frozen");
    // R7: holdover exit
    ref_valid = 4'b1000;
    step(M_LKG, 3, 0, 24'h000999, "R7 hold to locking");
    step(M_LKD, 3, 1, 24'h000999, "R7 locked");
    // R4: all lost without history
    ref_valid = 4'b0000; hist_avail = 0;
    step(M_FREE, 3, 0, CAL, "R4 free without history");
    // R8: forced free ignores references
    force_free = 1; ref_valid = 4'b0001;
    step(M_FREE, 3, 0, CAL, "R8 forced free ignores ref");
    force_free = 0;
    step(M_LKG, 0, 0, 24'h000999, "R8 release force");
    step(M_LKD, 0, 1, 24'h000999, "R8 relock");
    force_hold = 1; hist_avail = 1;
    step(M_HOLD, 0, 0, 24'h000999, "R8 forced hold");
    ref_valid = 4'b0011;
    step(M_HOLD, 0, 0, 24'h000999, "R8 forced hold ignores ref");
    force_free = 1;
    step(M_FREE, 0, 0, CAL, "R8 free beats hold");
    force_free = 0; hist_avail = 0;
    step(M_FREE, 0, 0, CAL, "R8 forced hold no history");
    force_hold = 0; ref_valid = 4'b0001;
    step(M_LKG, 0, 0, 24'h000999, "R2 after force");
    step(M_LKD, 0, 1, 24'h000999, "R3 locked ref0");
    // R10: manual selection
    man_sel_en = 1; man_sel_idx = 2'd2; ref_valid = 4'b0101;
    step(M_LKG, 2, 0, 24'h000999, "R10 manual switch");
    step(M_LKD, 2, 1, 24'h000999, "R10 manual locked");
    ref_valid = 4'b0001;
    step(M_FREE, 2, 0, CAL, "R10 manual ref lost");
    man_sel_en = 0;
    step(M_LKG, 0, 0, 24'h000999, "R10 manual off");
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule